// File: doc/BRIEF.md
# Modulo Circular Buffer Address Generator

This block keeps the index register that points into a circular buffer of `len_i` consecutive words starting at `base_i`. Each step strobe adds a signed modifier to the index. When the sum leaves the window, the block folds it back by one buffer length, so the pointer always runs around the ring. Software never has to compare the pointer against the buffer ends.

Every fold is recorded in a sticky status bit for its direction and also raises a one-cycle interrupt request. A step with an illegal modifier (zero, or larger in magnitude than the length) is refused and recorded in a sticky error bit. A synchronous load port sets the starting index.

A four-state controller records what the last clock edge did:
- `ST_IDLE` means no step was taken.
- `ST_ADV` means a step landed inside the window.
- `ST_WRAP` means a step folded around an end.
- `ST_REJ` means a step was refused.

From any state, the transitions are: load or no strobe goes to `ST_IDLE`; an illegal strobe goes to `ST_REJ`; a folding strobe goes to `ST_WRAP`; any other strobe goes to `ST_ADV`. The interrupt output is high exactly while the controller is in `ST_WRAP`.

Top module: `circ_addr_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the index becomes `base_i` and `wrap_up_o`, `wrap_dn_o`, `cfg_err_o` and `irq_o` become 0.
- R2: `load_i` high at an edge writes `load_idx_i` into the index. `load_i` takes priority over `step_i` in the same cycle.
- R3: A legal step whose sum stays in `[base_i, base_i+len_i-1]` sets the index to index + `mod_i`, with no flag change and `irq_o` low.
- R4: With `mod_i` positive and index + `mod_i` >= `base_i` + `len_i`, the new index is index + `mod_i` - `len_i`, and `wrap_up_o` is set.
- R5: With `mod_i` negative and index + `mod_i` < `base_i`, the new index is index + `mod_i` + `len_i`, and `wrap_dn_o` is set.
- R6: `irq_o` is high for exactly the cycle after each folding step (R4 or R5). Consecutive folding steps keep it high.
- R7: A step with `mod_i` = 0 or |`mod_i`| > `len_i` (two's complement) leaves the index unchanged, does not raise `irq_o`, and sets `cfg_err_o`.
- R8: `wrap_up_o`, `wrap_dn_o` and `cfg_err_o` hold until their clear input (`clr_up_i`, `clr_dn_i`, `clr_err_i`) is high at an edge. A new event in the same cycle as its clear wins.
- R9: With the index inside the window and the configuration steady, a legal step leaves the index inside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| base_i | input | AW | First address of the buffer |
| len_i | input | AW | Buffer length in words |
| mod_i | input | AW | Signed step added per strobe |
| load_i | input | 1 | Write `load_idx_i` into the index |
| load_idx_i | input | AW | Index value to load |
| step_i | input | 1 | Advance the index by one update |
| clr_up_i | input | 1 | Clear `wrap_up_o` |
| clr_dn_i | input | 1 | Clear `wrap_dn_o` |
| clr_err_i | input | 1 | Clear `cfg_err_o` |
| addr_o | output | AW | Current index / address |
| wrap_up_o | output | 1 | Sticky: folded past the top |
| wrap_dn_o | output | 1 | Sticky: folded below the base |
| cfg_err_o | output | 1 | Sticky: illegal modifier seen |
| irq_o | output | 1 | One-cycle interrupt request per fold |

## Verification
Every result of this block appears one clock edge after its stimulus:
- the new index;
- each status bit;
- the interrupt request, which comes from the controller state written at that same edge.

The bench changes inputs on the falling edge and reads outputs on the next falling edge, so each value is read half a period after the rising edge that produced it. The interrupt is read again one falling edge later to confirm that it drops after a single fold. Back-to-back folds are read on successive falling edges to confirm that it stays high.

// File: rtl/circ_pkg.sv
package circ_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADV,
        ST_WRAP,
        ST_REJ
    } agu_state_t;

    typedef struct packed {
        logic fold_up;
        logic fold_dn;
        logic bad_mod;
    } step_info_t;

endpackage

// File: rtl/circ_step_calc.sv
module circ_step_calc #(
    parameter int AW = 16
) (
    input  logic [AW-1:0]       idx_i,
    input  logic [AW-1:0]       base_i,
    input  logic [AW-1:0]       len_i,
    input  logic [AW-1:0]       mod_i,
    output logic [AW-1:0]       nxt_o,
    output circ_pkg::step_info_t info_o
);
    localparam int EW = AW + 2;

    logic signed [EW-1:0] s_idx, s_base, s_len, s_mod, s_mag, s_top, s_tent;
    logic                 mod_neg;

    always_comb begin
        mod_neg = mod_i[AW-1];
        s_idx   = signed'({2'b00, idx_i});
        s_base  = signed'({2'b00, base_i});
        s_len   = signed'({2'b00, len_i});
        s_mod   = signed'({{2{mod_neg}}, mod_i});
        s_mag   = mod_neg ? -s_mod : s_mod;
        s_top   = s_base + s_len;
        s_tent  = s_idx + s_mod;

        info_o         = '0;
        info_o.bad_mod = (mod_i == '0) || (s_mag > s_len);
        nxt_o          = AW'(s_tent);
        if (!mod_neg && (s_tent >= s_top)) begin
            info_o.fold_up = 1'b1;
            nxt_o          = AW'(s_tent - s_len);
        end else if (mod_neg && (s_tent < s_base)) begin
            info_o.fold_dn = 1'b1;
            nxt_o          = AW'(s_tent + s_len);
        end
    end
endmodule

// File: rtl/circ_sticky.sv
module circ_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_o[g] <= 1'b0;
            else if (set_i[g])
                flag_o[g] <= 1'b1;
            else if (clr_i[g])
                flag_o[g] <= 1'b0;
        end

        // R8: a set flag survives any cycle without its clear
        p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[g] && !clr_i[g]) |=> flag_o[g]);
    end
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] len_i,
    input  logic [AW-1:0] mod_i,
    input  logic          load_i,
    input  logic [AW-1:0] load_idx_i,
    input  logic          step_i,
    input  logic          clr_up_i,
    input  logic          clr_dn_i,
    input  logic          clr_err_i,
    output logic [AW-1:0] addr_o,
    output logic          wrap_up_o,
    output logic          wrap_dn_o,
    output logic          cfg_err_o,
    output logic          irq_o
);
    import circ_pkg::*;

    agu_state_t   state_q, state_d;
    logic [AW-1:0] idx_q, idx_nxt;
    step_info_t   info;
    logic         step_eff, step_ok;
    logic [2:0]   flag_set, flag_clr, flags;

    circ_step_calc #(.AW(AW)) u_calc (
        .idx_i  (idx_q),
        .base_i (base_i),
        .len_i  (len_i),
        .mod_i  (mod_i),
        .nxt_o  (idx_nxt),
        .info_o (info)
    );

    assign step_eff = step_i && !load_i;
    assign step_ok  = step_eff && !info.bad_mod;

    // next-state logic
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_ADV, ST_WRAP, ST_REJ: begin
                if (!step_eff)
                    state_d = ST_IDLE;
                else if (info.bad_mod)
                    state_d = ST_REJ;
                else if (info.fold_up || info.fold_dn)
                    state_d = ST_WRAP;
                else
                    state_d = ST_ADV;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // index register
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= base_i;
        else if (load_i)
            idx_q <= load_idx_i;
        else if (step_ok)
            idx_q <= idx_nxt;
    end

    assign flag_set = {step_ok && info.fold_up, step_ok && info.fold_dn, step_eff && info.bad_mod};
    assign flag_clr = {clr_up_i, clr_dn_i, clr_err_i};

    circ_sticky #(.N(3)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (flag_set),
        .clr_i  (flag_clr),
        .flag_o (flags)
    );

    // outputs
    always_comb begin
        addr_o    = idx_q;
        wrap_up_o = flags[2];
        wrap_dn_o = flags[1];
        cfg_err_o = flags[0];
        irq_o     = (state_q == ST_WRAP);
    end

    // R1: reset forces index to base and quiet flags
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (addr_o == $past(base_i) && !irq_o && !wrap_up_o && !wrap_dn_o && !cfg_err_o));

    // R2: load writes the index
    p_load_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (addr_o == $past(load_idx_i)));

    // R6: request only follows a non-load step
    p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_d == ST_WRAP) |=> irq_o);
    p_irq_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(step_i && !load_i));

    // R7: zero modifier never moves the index nor raises a request
    p_zero_mod_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && mod_i == '0) |=> ($stable(addr_o) && !irq_o && cfg_err_o));

    // R9: in-window index stays in window after a legal step
    p_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ok && addr_o >= base_i
            && ({1'b0, addr_o} < ({1'b0, base_i} + {1'b0, len_i})))
        |=> (addr_o >= $past(base_i)
            && ({1'b0, addr_o} < ({1'b0, $past(base_i)} + {1'b0, $past(len_i)}))));
endmodule

// File: tb/circ_addr_gen_tb_top.sv
`timescale 1ns/1ps
module circ_addr_gen_tb_top;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] base_i = 16'd100;
    logic [AW-1:0] len_i = 16'd10;
    logic [AW-1:0] mod_i = '0;
    logic          load_i = 1'b0;
    logic [AW-1:0] load_idx_i = '0;
    logic          step_i = 1'b0;
    logic          clr_up_i = 1'b0;
    logic          clr_dn_i = 1'b0;
    logic          clr_err_i = 1'b0;
    logic [AW-1:0] addr_o;
    logic          wrap_up_o, wrap_dn_o, cfg_err_o, irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    circ_addr_gen #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .base_i(base_i), .len_i(len_i), .mod_i(mod_i),
        .load_i(load_i), .load_idx_i(load_idx_i), .step_i(step_i),
        .clr_up_i(clr_up_i), .clr_dn_i(clr_dn_i), .clr_err_i(clr_err_i),
        .addr_o(addr_o), .wrap_up_o(wrap_up_o), .wrap_dn_o(wrap_dn_o),
        .cfg_err_o(cfg_err_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_load(input int v);
        @(negedge clk); load_i = 1'b1; load_idx_i = AW'(v);
        @(negedge clk); load_i = 1'b0;
    endtask

    task automatic do_step(input int m);
        @(negedge clk); mod_i = AW'(m); step_i = 1'b1;
        @(negedge clk); step_i = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk); clr_up_i = 1'b1; clr_dn_i = 1'b1; clr_err_i = 1'b1;
        @(negedge clk); clr_up_i = 1'b0; clr_dn_i = 1'b0; clr_err_i = 1'b0;
    endtask

    task automatic t_reset(input int b);
        @(negedge clk); rst_n = 1'b0; base_i = AW'(b);
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        chk("R1 addr", int'(addr_o), b);
        chk("R1 flags", int'({wrap_up_o, wrap_dn_o, cfg_err_o, irq_o}), 0);
    endtask

    task automatic t_plain_and_up();
        do_load(105);
        chk("R2 load", int'(addr_o), 105);
        do_step(3);
        chk("R3 add", int'(addr_o), 108);
        chk("R3 no irq", int'(irq_o), 0);
        chk("R3 no flag", int'(wrap_up_o), 0);
        do_step(3);
        chk("R4 fold addr", int'(addr_o), 101);
        chk("R4 wrap_up", int'(wrap_up_o), 1);
        chk("R6 irq high", int'(irq_o), 1);
        @(negedge clk);
        chk("R6 irq drops", int'(irq_o), 0);
        chk("R8 sticky up", int'(wrap_up_o), 1);
        @(negedge clk); clr_up_i = 1'b1;
        @(negedge clk); clr_up_i = 1'b0;
        chk("R8 clear up", int'(wrap_up_o), 0);
    endtask

    task automatic t_down();
        do_load(101);
        do_step(-4);
        chk("R5 fold addr", int'(addr_o), 107);
        chk("R5 wrap_dn", int'(wrap_dn_o), 1);
        chk("R6 irq dn", int'(irq_o), 1);
        @(negedge clk); mod_i = AW'(-10); step_i = 1'b1;
        @(negedge clk);
        chk("R5 full-length down", int'(addr_o), 107);
        chk("R6 irq back-to-back", int'(irq_o), 1);
        mod_i = AW'(10);
        @(negedge clk); step_i = 1'b0;
        chk("R4 full-length up", int'(addr_o), 107);
        chk("R4 wrap_up", int'(wrap_up_o), 1);
        chk("R6 irq third", int'(irq_o), 1);
    endtask

    task automatic t_invalid();
        clear_all();
        do_step(0);
        chk("R7 zero held", int'(addr_o), 107);
        chk("R7 zero err", int'(cfg_err_o), 1);
        chk("R7 zero no irq", int'(irq_o), 0);
        clear_all();
        chk("R8 clear err", int'(cfg_err_o), 0);
        do_step(11);
        chk("R7 big held", int'(addr_o), 107);
        chk("R7 big err", int'(cfg_err_o), 1);
        chk("R7 big no flag", int'(wrap_up_o), 0);
        clear_all();
        do_step(-11);
        chk("R7 neg big held", int'(addr_o), 107);
        chk("R7 neg big err", int'(cfg_err_o), 1);
        chk("R7 neg no flag", int'(wrap_dn_o), 0);
    endtask

    task automatic t_set_wins();
        clear_all();
        @(negedge clk); mod_i = AW'(5); step_i = 1'b1; clr_up_i = 1'b1;
        @(negedge clk); step_i = 1'b0; clr_up_i = 1'b0;
        chk("R8 set wins addr", int'(addr_o), 102);
        chk("R8 set wins flag", int'(wrap_up_o), 1);
    endtask

    task automatic t_load_priority();
        @(negedge clk); load_i = 1'b1; load_idx_i = AW'(103); mod_i = AW'(3); step_i = 1'b1;
        @(negedge clk); load_i = 1'b0; step_i = 1'b0;
        chk("R2 load over step", int'(addr_o), 103);
    endtask

    task automatic t_sweep();
        int e = 103;
        for (int k = 0; k < 30; k++) begin
            int m = (k % 2 == 0) ? 7 : -3;
            do_step(m);
            e = e + m;
            if (e >= 110) e = e - 10;
            if (e < 100) e = e + 10;
            chk("R9 sweep", int'(addr_o), e);
        end
    endtask

    initial begin
        t_reset(100);
        t_plain_and_up();
        t_down();
        t_invalid();
        t_set_wins();
        t_load_priority();
        t_sweep();
        t_reset(200);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule